// File: doc/BRIEF.md
# Tagged Receive Byte Buffer with Overrun Stall

This block sits between a serial frame receiver and whatever drains received bytes, a processor or a DMA engine. Every stored entry carries one data byte and three tag bits: end-of-frame, CRC error and overrun. The oldest entry is always presented on the read side (first-word fall-through), and a single service request line tells the reader when there is enough to fetch. The request is raised when a word's worth of bytes is stored, or when any stored entry ends a frame, so that short frame tails are not left waiting.

If the receiver offers a byte while the buffer is full, that byte is lost. The block then goes back to the newest stored entry and sets both its overrun and end-of-frame tags, and it raises a stall output. While the stall is up, every byte offered by the receiver is discarded. The stall drops on the clock edge at which the last stored entry is read. Dropping the receive enable empties the buffer and clears the stall on the next edge.

The tag rewrite on overrun uses its own write port into the entry storage, separate from the normal push port. `DEPTH` must be at least 2.

Top module: `rx_tag_fifo`

## Requirements
- R1: After reset the buffer is empty: `empty`=1, `full`=0, `level`=0, `svc_req`=0, `stall`=0.
- R2: Entries are read in write order. While `empty`=0 the oldest entry's byte and tags appear on `rd_data`, `rd_eof`, `rd_crc_err` and `rd_ovr`, and `rd_en` removes that entry at the next clock edge. `rd_en` has no effect while empty.
- R3: `level` gives the number of stored entries and never exceeds `DEPTH`. `full` is 1 exactly when `level`=`DEPTH`, and `empty` is 1 exactly when `level`=0.
- R4: `svc_req` is 1 exactly when `level` is at least `THRESH` (default 4) or at least one stored entry has its end-of-frame tag set.
- R5: A write (`wr_valid`=1 while enabled and not stalled) that arrives while `full`=1 stores nothing. Its byte is dropped, and the newest stored entry gets `ovr`=1 and `eof`=1 while its data byte and CRC tag stay unchanged. `rd_ovr` is 0 for every entry that no overrun has marked.
- R6: An overrun sets `stall` at the next edge. While `stall`=1 every write is ignored. `stall` clears at the edge where `level` reaches 0.
- R7: While `rx_enable`=0, writes and reads are ignored, and at the next edge the buffer is empty with `stall`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_enable | input | 1 | Receive enable; low empties the buffer |
| wr_valid | input | 1 | Receiver offers a byte this cycle |
| wr_data | input | 8 | Offered byte |
| wr_eof | input | 1 | Offered byte ends its frame |
| wr_crc_err | input | 1 | Frame of the offered byte failed its CRC |
| rd_en | input | 1 | Reader removes the head entry |
| rd_data | output | 8 | Head entry byte |
| rd_eof | output | 1 | Head entry end-of-frame tag |
| rd_crc_err | output | 1 | Head entry CRC-error tag |
| rd_ovr | output | 1 | Head entry overrun tag |
| level | output | $clog2(DEPTH+1) | Number of stored entries |
| empty | output | 1 | No entry stored |
| full | output | 1 | DEPTH entries stored |
| svc_req | output | 1 | Service request to the reader |
| stall | output | 1 | Discard receiver input until drained |

## Verification
A corrupted pointer or count shows on the very next read as a wrong head byte or a `level` that no longer matches the entries written minus those read. An end-of-frame counter that drifts shows as `svc_req` stuck high after the last tagged entry leaves, or low while a short tagged frame waits. A tag rewrite aimed at the wrong slot shows only when that slot reaches the head, up to `DEPTH` reads later. A stall that releases early shows in the same cycle as an extra stored entry.

// File: rtl/frame_rx_pkg.sv
package frame_rx_pkg;

    typedef struct packed {
        logic       ovr;
        logic       crc_err;
        logic       eof;
        logic [7:0] data;
    } rx_entry_t;

endpackage

// File: rtl/rx_entry_store.sv
module rx_entry_store
    import frame_rx_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic            clk,
    input  logic            push_en,
    input  logic [AW-1:0]   push_addr,
    input  rx_entry_t       push_entry,
    input  logic            mark_en,
    input  logic [AW-1:0]   mark_addr,
    input  logic [AW-1:0]   rd_addr,
    output rx_entry_t       rd_entry,
    output logic            mark_eof_old
);

    rx_entry_t mem_q [DEPTH];

    // Normal push port and tail tag rewrite port; the controller never
    // aims both at the same slot in one cycle (rewrite only when full).
    always_ff @(posedge clk) begin
        if (push_en) begin
            mem_q[push_addr] <= push_entry;
        end
        if (mark_en) begin
            mem_q[mark_addr].ovr <= 1'b1;
            mem_q[mark_addr].eof <= 1'b1;
        end
    end

    assign rd_entry     = mem_q[rd_addr];
    assign mark_eof_old = mem_q[mark_addr].eof;

endmodule

// File: rtl/rx_fifo_ctrl.sv
module rx_fifo_ctrl #(
    parameter int DEPTH  = 16,
    parameter int THRESH = 4,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            enable,
    input  logic            wr_valid,
    input  logic            wr_eof,
    input  logic            rd_en,
    input  logic            head_eof,
    input  logic            tail_eof_old,
    output logic            push_en,
    output logic [AW-1:0]   wptr,
    output logic            mark_en,
    output logic [AW-1:0]   tail_ptr,
    output logic [AW-1:0]   rptr,
    output logic [CW-1:0]   level,
    output logic            empty,
    output logic            full,
    output logic            stall,
    output logic            svc_req
);

    typedef struct packed {
        logic [AW-1:0] wptr;
        logic [AW-1:0] rptr;
        logic [CW-1:0] count;
        logic [CW-1:0] eof_cnt;
        logic          stall;
    } ctrl_st_t;

    ctrl_st_t st_d, st_q;

    logic accept_wr, push, ovr_ev, pop;

    function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_comb begin
        st_d      = st_q;
        accept_wr = enable && wr_valid && !st_q.stall;
        push      = accept_wr && (st_q.count != CW'(DEPTH));
        ovr_ev    = accept_wr && (st_q.count == CW'(DEPTH));
        pop       = enable && rd_en && (st_q.count != '0);

        if (push) st_d.wptr = ptr_inc(st_q.wptr);
        if (pop)  st_d.rptr = ptr_inc(st_q.rptr);
        st_d.count   = st_q.count + CW'(push) - CW'(pop);
        st_d.eof_cnt = st_q.eof_cnt
                     + CW'(push && wr_eof)
                     + CW'(ovr_ev && !tail_eof_old)
                     - CW'(pop && head_eof);

        if (ovr_ev) st_d.stall = 1'b1;
        else        st_d.stall = st_q.stall && (st_d.count != '0);

        if (!enable) st_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign push_en  = push;
    assign mark_en  = ovr_ev;
    assign wptr     = st_q.wptr;
    assign rptr     = st_q.rptr;
    assign tail_ptr = (st_q.wptr == '0) ? AW'(DEPTH - 1) : st_q.wptr - AW'(1);
    assign level    = st_q.count;
    assign empty    = (st_q.count == '0);
    assign full     = (st_q.count == CW'(DEPTH));
    assign stall    = st_q.stall;
    assign svc_req  = (st_q.count >= CW'(THRESH)) || (st_q.eof_cnt != '0);

endmodule

// File: rtl/rx_tag_fifo.sv
module rx_tag_fifo
    import frame_rx_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int THRESH = 4,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_enable,
    input  logic          wr_valid,
    input  logic [7:0]    wr_data,
    input  logic          wr_eof,
    input  logic          wr_crc_err,
    input  logic          rd_en,
    output logic [7:0]    rd_data,
    output logic          rd_eof,
    output logic          rd_crc_err,
    output logic          rd_ovr,
    output logic [CW-1:0] level,
    output logic          empty,
    output logic          full,
    output logic          svc_req,
    output logic          stall
);

    logic          push_en, mark_en, tail_eof_old;
    logic [AW-1:0] wptr, tail_ptr, rptr;
    rx_entry_t     push_entry, head;

    assign push_entry = '{ovr: 1'b0, crc_err: wr_crc_err, eof: wr_eof, data: wr_data};

    rx_fifo_ctrl #(.DEPTH(DEPTH), .THRESH(THRESH)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable       (rx_enable),
        .wr_valid     (wr_valid),
        .wr_eof       (wr_eof),
        .rd_en        (rd_en),
        .head_eof     (head.eof),
        .tail_eof_old (tail_eof_old),
        .push_en      (push_en),
        .wptr         (wptr),
        .mark_en      (mark_en),
        .tail_ptr     (tail_ptr),
        .rptr         (rptr),
        .level        (level),
        .empty        (empty),
        .full         (full),
        .stall        (stall),
        .svc_req      (svc_req)
    );

    rx_entry_store #(.DEPTH(DEPTH)) u_store (
        .clk          (clk),
        .push_en      (push_en),
        .push_addr    (wptr),
        .push_entry   (push_entry),
        .mark_en      (mark_en),
        .mark_addr    (tail_ptr),
        .rd_addr      (rptr),
        .rd_entry     (head),
        .mark_eof_old (tail_eof_old)
    );

    assign rd_data    = head.data;
    assign rd_eof     = head.eof;
    assign rd_crc_err = head.crc_err;
    assign rd_ovr     = head.ovr;

endmodule

// File: rtl/rx_tag_fifo_chk.sv
module rx_tag_fifo_chk #(
    parameter int DEPTH  = 16,
    parameter int THRESH = 4,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rx_enable,
    input logic          wr_valid,
    input logic          rd_en,
    input logic [CW-1:0] level,
    input logic          empty,
    input logic          full,
    input logic          svc_req,
    input logic          stall
);

    assert_level_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        level <= CW'(DEPTH));

    assert_full_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !empty);

    assert_svc_thresh_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (level >= CW'(THRESH)) |-> svc_req);

    assert_svc_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> !svc_req);

    assert_ovr_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_enable && wr_valid && full && !stall) |=>
        (stall && level == ($past(rd_en) ? $past(level) - CW'(1) : $past(level))));

    assert_stall_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_enable && stall && !rd_en) |=> (stall && level == $past(level)));

    assert_stall_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_enable && stall && rd_en && level == CW'(1)) |=> (!stall && empty));

    assert_disable_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_enable |=> (empty && !stall));

endmodule

bind rx_tag_fifo rx_tag_fifo_chk #(.DEPTH(DEPTH), .THRESH(THRESH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_enable (rx_enable),
    .wr_valid  (wr_valid),
    .rd_en     (rd_en),
    .level     (level),
    .empty     (empty),
    .full      (full),
    .svc_req   (svc_req),
    .stall     (stall)
);

// File: tb/test_rx_tag_fifo.sv
`timescale 1ns/1ps
module test_rx_tag_fifo;

    localparam int DEPTH  = 16;
    localparam int THRESH = 4;
    localparam int CW     = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rx_enable = 1'b0;
    logic          wr_valid = 1'b0;
    logic [7:0]    wr_data = '0;
    logic          wr_eof = 1'b0;
    logic          wr_crc_err = 1'b0;
    logic          rd_en = 1'b0;
    logic [7:0]    rd_data;
    logic          rd_eof, rd_crc_err, rd_ovr;
    logic [CW-1:0] level;
    logic          empty, full, svc_req, stall;

    int nchecks = 0;
    int nerr = 0;
    bit done = 1'b0;

    // model entry layout (bench only): {ovr, crc, eof, data[7:0]}
    logic [10:0] mq[$];
    bit          m_stall = 1'b0;

    always #2.5 clk = ~clk;

    rx_tag_fifo #(.DEPTH(DEPTH), .THRESH(THRESH)) i_rx_tag_fifo (
        .clk(clk), .rst_n(rst_n), .rx_enable(rx_enable), .wr_valid(wr_valid),
        .wr_data(wr_data), .wr_eof(wr_eof), .wr_crc_err(wr_crc_err), .rd_en(rd_en),
        .rd_data(rd_data), .rd_eof(rd_eof), .rd_crc_err(rd_crc_err), .rd_ovr(rd_ovr),
        .level(level), .empty(empty), .full(full), .svc_req(svc_req), .stall(stall)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchecks++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit exp_svc();
        bit any_eof = 1'b0;
        foreach (mq[i]) if (mq[i][8]) any_eof = 1'b1;
        return (mq.size() >= THRESH) || any_eof;
    endfunction

    task automatic compare_all();
        chk("R3 level", 32'(level), 32'(mq.size()));
        chk("R3 empty", 32'(empty), 32'(mq.size() == 0));
        chk("R3 full", 32'(full), 32'(mq.size() == DEPTH));
        chk("R4 svc_req", 32'(svc_req), 32'(exp_svc()));
        chk("R6 stall", 32'(stall), 32'(m_stall));
        if (mq.size() != 0) begin
            chk("R2 head data", 32'(rd_data), 32'(mq[0][7:0]));
            chk("R2 head eof/crc", 32'({rd_crc_err, rd_eof}), 32'(mq[0][9:8]));
            chk("R5 head ovr", 32'(rd_ovr), 32'(mq[0][10]));
        end
    endtask

    task automatic model_update(input bit en, input bit wv, input logic [7:0] wd,
                                input bit we, input bit wc, input bit rdv);
        bit ovr_ev, pop, push;
        if (!en) begin
            mq.delete();
            m_stall = 1'b0;
            return;
        end
        ovr_ev = wv && !m_stall && (mq.size() == DEPTH);
        push   = wv && !m_stall && (mq.size() < DEPTH);
        pop    = rdv && (mq.size() != 0);
        if (ovr_ev) begin
            mq[mq.size()-1][10] = 1'b1;
            mq[mq.size()-1][8]  = 1'b1;
        end
        if (pop) void'(mq.pop_front());
        if (push) mq.push_back({1'b0, wc, we, wd});
        if (ovr_ev) m_stall = 1'b1;
        else if (m_stall && mq.size() == 0) m_stall = 1'b0;
    endtask

    task automatic step(input bit en, input bit wv, input logic [7:0] wd,
                        input bit we, input bit wc, input bit rdv);
        @(negedge clk);
        compare_all();
        rx_enable = en; wr_valid = wv; wr_data = wd;
        wr_eof = we; wr_crc_err = wc; rd_en = rdv;
        @(posedge clk);
        model_update(en, wv, wd, we, wc, rdv);
    endtask

    task automatic finish_run();
        $display("  Result: errors=%0d of %0d checks", nerr, nchecks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nchecks++;
            nerr++;
            $display("FAIL watchdog R2 actual=hung expected=finished");
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk("R1 empty", 32'(empty), 32'd1);
        chk("R1 full", 32'(full), 32'd0);
        chk("R1 level", 32'(level), 32'd0);
        chk("R1 svc_req", 32'(svc_req), 32'd0);
        chk("R1 stall", 32'(stall), 32'd0);

        // R4: short frame ending with eof raises request below threshold
        step(1, 1, 8'h11, 0, 0, 0);
        step(1, 1, 8'h22, 1, 1, 0);
        step(1, 0, 8'h00, 0, 0, 0);
        chk("R4 short frame svc", 32'(svc_req), 32'd1);
        // R2: read from empty is ignored afterwards
        for (int i = 0; i < 4; i++) step(1, 0, 8'h00, 0, 0, 1);
        step(1, 0, 8'h00, 0, 0, 0);

        // R5/R6: fill, overrun, ignored writes during stall
        for (int i = 0; i < DEPTH; i++) step(1, 1, 8'(8'h40 + i), 0, (i == DEPTH - 1), 0);
        step(1, 1, 8'hAA, 0, 0, 0);
        step(1, 1, 8'hBB, 1, 0, 0);
        step(1, 1, 8'hCC, 0, 0, 0);
        @(negedge clk);
        chk("R6 stall after overrun", 32'(stall), 32'd1);
        chk("R5 level kept", 32'(level), 32'(DEPTH));
        for (int i = 0; i < DEPTH; i++) step(1, (i % 2) == 0, 8'hEE, 0, 0, 1);
        @(negedge clk);
        chk("R6 stall released at empty", 32'(stall), 32'd0);
        chk("R6 nothing stored during stall", 32'(level), 32'd0);
        step(1, 1, 8'h5A, 0, 0, 0);
        step(1, 0, 8'h00, 0, 0, 0);
        @(negedge clk);
        chk("R6 writes accepted again", 32'(level), 32'd1);

        // R7: disable empties buffer and clears stall
        for (int i = 0; i < DEPTH + 1; i++) step(1, 1, 8'(i), 0, 0, 0);
        step(0, 1, 8'h77, 1, 0, 1);
        @(negedge clk);
        chk("R7 level after disable", 32'(level), 32'd0);
        chk("R7 stall after disable", 32'(stall), 32'd0);
        step(0, 1, 8'h78, 1, 0, 0);
        step(1, 0, 8'h00, 0, 0, 0);

        // random phases with different drain rates
        for (int ph = 0; ph < 6; ph++) begin
            int rd_pct;
            rd_pct = (ph % 3 == 0) ? 10 : ((ph % 3 == 1) ? 50 : 90);
            for (int c = 0; c < 600; c++) begin
                bit en, wv, we, wc, rdv;
                en  = ($urandom_range(0, 199) != 0);
                wv  = ($urandom_range(0, 99) < 60);
                we  = ($urandom_range(0, 7) == 0);
                wc  = ($urandom_range(0, 15) == 0);
                rdv = ($urandom_range(0, 99) < rd_pct);
                step(en, wv, 8'($urandom), we, wc, rdv);
            end
        end
        for (int i = 0; i < DEPTH + 2; i++) step(1, 0, 8'h00, 0, 0, 1);
        @(negedge clk);
        compare_all();
        done = 1'b1;
        finish_run();
    end

endmodule